// File: doc/BRIEF.md
# Configurable Per-Pin Interrupt Detector for a GPIO Bank

This block watches the synchronised levels of a bank of general-purpose pins, organised as several ports of eight pins each, and turns selected conditions on each pin into latched status bits and a single interrupt line. Each pin has its own three-bit trigger setting. The setting picks edge or level sensing, picks the active polarity, and can ask for detection on both edges. Edge events are latched in a per-pin status bit. Software clears a latched bit by writing a one to the matching bit of the clear strobe. A pin requests service when its status bit and its enable bit are both set. The requests of every port are ORed into one registered bank interrupt.

The block sits behind a register decoder that is not part of this project. The decoder presents the trigger words, the enable mask and a one-cycle clear strobe as plain vectors. It reads the status vector back. The pin inputs must already be synchronised to `clk`.

Top module: `gpio_bank_irq`

## Requirements
- R1: Bit index layout: pin i of port k is bit k*PINS+i of `pin_lvl`, `irq_en`, `sts_clr` and `sts`. In `trig_cfg`, the field for port k starts at bit k*3*PINS. Within that field, bit i is the polarity, bit PINS+i selects edge sensing, and bit 2*PINS+i selects both edges. Rising-edge mode (polarity=1, edge=1, both=0) sets the pin's status bit on the clock edge that follows the first cycle in which the level is 1 after a cycle in which it was 0.
- R2: Falling-edge mode (polarity=0, edge=1, both=0) sets the status bit on the clock edge that follows a 1-to-0 change. A 0-to-1 change has no effect on the status bit.
- R3: Both-edges mode (both=1, edge=1) sets the status bit after either change, whatever the polarity bit holds.
- R4: In level mode (edge=0), the status bit is set on every clock edge at which the level equals the polarity bit. While that level persists, a clear cannot leave the bit at 0.
- R5: A 1 in bit p of `sts_clr` clears status bit p on the next clock edge. A 0 in `sts_clr` leaves the bit unchanged.
- R6: If a detection and a clear for the same pin occur in the same cycle, the status bit ends up set.
- R7: `irq` is registered. In cycle n+1 it equals the OR, across all ports and pins, of `sts` AND `irq_en` as sampled in cycle n. A set status bit whose enable bit is 0 does not raise `irq`.
- R8: In the cycle in which a pin's three trigger bits differ from their value in the previous cycle, that pin reports no edge event.
- R9: While `rst` is high at a clock edge, `sts` and `irq` become 0.
- R10: Edge detection compares the current level with the level held one cycle earlier. A steady level therefore gives a single event. A new edge that arrives after a clear sets the bit again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | PORTS*PINS | Synchronised pin levels |
| trig_cfg | input | PORTS*3*PINS | Trigger settings, one 3*PINS field per port |
| irq_en | input | PORTS*PINS | Per-pin interrupt enable |
| sts_clr | input | PORTS*PINS | Write-one-to-clear strobe for status |
| sts | output | PORTS*PINS | Latched per-pin status |
| irq | output | 1 | Registered bank interrupt |

## Verification
The hardest case to reach is the same-cycle collision. In it, a pin's trigger bits change in the same cycle as its level, or a clear lands in the same cycle as a fresh edge. These cases only occur when two independent inputs move on one exact cycle. Directed sequences set them up on a quiet pin: the level and the trigger word change together, and a clear strobe is timed onto the cycle of a new edge. A long random phase then re-draws the trigger modes, the levels, the enables and the clear bits on every cycle. A behavioural model follows every pin and is compared on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Trigger setting of one pin, gathered from three bit-planes of the port word
  typedef struct packed {
    logic both;   // detect both edges (edge mode only)
    logic edge_s; // 1: edge sensed, 0: level sensed
    logic pol;    // 1: rising/high, 0: falling/low
  } pin_cfg_t;

  // Detection condition for one pin, before type-change suppression
  function automatic logic raw_event(input pin_cfg_t c, input logic cur, input logic prev);
    logic r;
    if (c.edge_s) begin
      if (c.both)     r = cur ^ prev;
      else if (c.pol) r = cur & ~prev;
      else            r = ~cur & prev;
    end else begin
      r = (cur == c.pol);
    end
    return r;
  endfunction

endpackage

// File: rtl/gpio_pin_det.sv
module gpio_pin_det
  import gpio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     lvl,
  input  pin_cfg_t cfg,
  input  logic     clr,
  output logic     sts
);

  logic     prev_q;
  pin_cfg_t cfg_q;
  logic     sts_q;
  logic     cfg_chg;
  logic     ev_raw;
  logic     ev;

  always_comb begin
    cfg_chg = (cfg != cfg_q);
    ev_raw  = raw_event(cfg, lvl, prev_q);
    // an edge-sensed pin whose setting just moved reports nothing this cycle
    ev      = ev_raw & ~(cfg.edge_s & cfg_chg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cfg_q  <= '0;
      sts_q  <= 1'b0;
    end else begin
      prev_q <= lvl;
      cfg_q  <= cfg;
      sts_q  <= ev | (sts_q & ~clr);
    end
  end

  assign sts = sts_q;

  p_rise_r1: assert property (@(posedge clk) disable iff (rst)
    (cfg.edge_s && !cfg.both && cfg.pol && !cfg_chg && lvl && !prev_q) |=> sts_q);

  p_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg.edge_s && !cfg.both && !cfg.pol && !cfg_chg && !lvl && prev_q) |=> sts_q);

  p_both_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg.edge_s && cfg.both && !cfg_chg && (lvl != prev_q)) |=> sts_q);

  p_level_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg.edge_s && (lvl == cfg.pol)) |=> sts_q);

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr && !ev) |=> !sts_q);

  p_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && sts_q) |=> sts_q);

  p_cfg_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_chg && cfg.edge_s && !sts_q) |=> !sts_q);

endmodule

// File: rtl/gpio_port_det.sv
module gpio_port_det
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   lvl,
  input  logic [3*PINS-1:0] typ,
  input  logic [PINS-1:0]   en,
  input  logic [PINS-1:0]   clr,
  output logic [PINS-1:0]   sts,
  output logic              req
);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_cfg_t c;
    assign c.pol    = typ[i];
    assign c.edge_s = typ[PINS + i];
    assign c.both   = typ[2*PINS + i];

    gpio_pin_det u_pin (
      .clk (clk),
      .rst (rst),
      .lvl (lvl[i]),
      .cfg (c),
      .clr (clr[i]),
      .sts (sts[i])
    );
  end

  assign req = |(sts & en);

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int PORTS = 4,
  parameter int PINS  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PORTS*PINS-1:0]     pin_lvl,
  input  logic [PORTS*3*PINS-1:0]   trig_cfg,
  input  logic [PORTS*PINS-1:0]     irq_en,
  input  logic [PORTS*PINS-1:0]     sts_clr,
  output logic [PORTS*PINS-1:0]     sts,
  output logic                      irq
);

  localparam int NB = PORTS * PINS;
  localparam int TW = 3 * PINS;

  logic [PORTS-1:0] port_req;
  logic             irq_q;

  for (genvar k = 0; k < PORTS; k++) begin : g_port
    gpio_port_det #(.PINS(PINS)) u_port (
      .clk (clk),
      .rst (rst),
      .lvl (pin_lvl[k*PINS +: PINS]),
      .typ (trig_cfg[k*TW +: TW]),
      .en  (irq_en[k*PINS +: PINS]),
      .clr (sts_clr[k*PINS +: PINS]),
      .sts (sts[k*PINS +: PINS]),
      .req (port_req[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |port_req;
  end

  assign irq = irq_q;

  p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
    (|(sts & irq_en)) |=> irq);

  p_irq_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !(|(sts & irq_en)) |=> !irq);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (sts == {NB{1'b0}} && !irq));

endmodule

// File: tb/gpio_bank_irq_tb.sv
module gpio_bank_irq_tb;

  localparam int CLK_P = 10;
  localparam int PORTS = 4;
  localparam int PINS  = 8;
  localparam int NB    = PORTS * PINS;
  localparam int TW    = 3 * PINS;

  // trigger codes {both, edge, pol}
  localparam logic [2:0] T_RISE = 3'b011;
  localparam logic [2:0] T_FALL = 3'b010;
  localparam logic [2:0] T_BOTH = 3'b110;
  localparam logic [2:0] T_HIGH = 3'b001;
  localparam logic [2:0] T_LOW  = 3'b000;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NB-1:0]       pin_lvl = '0;
  logic [PORTS*TW-1:0] trig_cfg = '0;
  logic [NB-1:0]       irq_en = '0;
  logic [NB-1:0]       sts_clr = '0;
  logic [NB-1:0]       sts;
  logic                irq;

  int    n_chk = 0;
  int    n_fail = 0;
  string tag = "R9";

  // behavioural model state
  bit       m_prev [NB];
  bit [2:0] m_cfg  [NB];
  bit       m_sts  [NB];
  bit       m_irq;

  always #(CLK_P/2) clk = ~clk;

  gpio_bank_irq #(.PORTS(PORTS), .PINS(PINS)) u_dut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .trig_cfg(trig_cfg),
    .irq_en(irq_en), .sts_clr(sts_clr), .sts(sts), .irq(irq)
  );

  function automatic bit [2:0] get_code(int g);
    int k = g / PINS;
    int i = g % PINS;
    return {trig_cfg[k*TW + 2*PINS + i], trig_cfg[k*TW + PINS + i], trig_cfg[k*TW + i]};
  endfunction

  task automatic set_code(int g, bit [2:0] c);
    int k = g / PINS;
    int i = g % PINS;
    trig_cfg[k*TW + i]          = c[0];
    trig_cfg[k*TW + PINS + i]   = c[1];
    trig_cfg[k*TW + 2*PINS + i] = c[2];
  endtask

  always @(posedge clk) begin
    bit any;
    any = 1'b0;
    for (int g = 0; g < NB; g++) any |= m_sts[g] & irq_en[g];
    if (rst) begin
      m_irq = 1'b0;
      for (int g = 0; g < NB; g++) begin
        m_prev[g] = 1'b0; m_cfg[g] = 3'b000; m_sts[g] = 1'b0;
      end
    end else begin
      m_irq = any;
      for (int g = 0; g < NB; g++) begin
        bit [2:0] c;
        bit cur, hit;
        c   = get_code(g);
        cur = pin_lvl[g];
        if (!c[1])    hit = (cur == c[0]);
        else if (c[2]) hit = (cur != m_prev[g]);
        else if (c[0]) hit = cur && !m_prev[g];
        else           hit = !cur && m_prev[g];
        if (c[1] && (c != m_cfg[g])) hit = 1'b0;
        m_sts[g]  = hit ? 1'b1 : (sts_clr[g] ? 1'b0 : m_sts[g]);
        m_prev[g] = cur;
        m_cfg[g]  = c;
      end
    end
  end

  task automatic compare();
    logic [NB-1:0] exp_s;
    for (int g = 0; g < NB; g++) exp_s[g] = m_sts[g];
    n_chk++;
    if (sts !== exp_s) begin
      n_fail++;
      $display("FAIL %s sts actual=%h expected=%h", tag, sts, exp_s);
    end
    n_chk++;
    if (irq !== m_irq) begin
      n_fail++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq);
    end
  endtask

  task automatic tick(int n = 1);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      compare();
    end
  endtask

  // directed check of one status bit against an explicit value
  task automatic expect_bit(int g, bit e, string t);
    n_chk++;
    if (sts[g] !== e) begin
      n_fail++;
      $display("FAIL %s pin %0d actual=%b expected=%b", t, g, sts[g], e);
    end
  endtask

  task automatic clear(int g);
    sts_clr[g] = 1'b1; tick(); sts_clr = '0;
  endtask

  initial begin
    #(CLK_P*200000);
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tag = "R9"; tick(3);
    n_chk++;
    if (sts !== '0 || irq !== 1'b0) begin
      n_fail++; $display("FAIL R9 reset actual=%h/%b expected=0/0", sts, irq);
    end
    rst = 1'b0;
    for (int g = 0; g < NB; g++) set_code(g, T_FALL);
    irq_en = '1;
    tick(3);

    // R1 rising on pin 0
    tag = "R1"; set_code(0, T_RISE); tick(2);
    pin_lvl[0] = 1'b1; tick(); expect_bit(0, 1'b1, "R1");
    // R10 steady level gives one event, clear holds
    tag = "R10"; clear(0); tick(3); expect_bit(0, 1'b0, "R10");
    pin_lvl[0] = 1'b0; tick(); expect_bit(0, 1'b0, "R1");
    pin_lvl[0] = 1'b1; tick(); expect_bit(0, 1'b1, "R10");
    clear(0);

    // R2 falling on pin 9 (port 1)
    tag = "R2"; pin_lvl[9] = 1'b1; tick(2); expect_bit(9, 1'b0, "R2");
    pin_lvl[9] = 1'b0; tick(); expect_bit(9, 1'b1, "R2");
    clear(9);

    // R3 both edges on pin 20
    tag = "R3"; set_code(20, T_BOTH); tick(2);
    pin_lvl[20] = 1'b1; tick(); expect_bit(20, 1'b1, "R3");
    clear(20); tick();
    pin_lvl[20] = 1'b0; tick(); expect_bit(20, 1'b1, "R3");
    clear(20);

    // R4 level high on pin 31 holds against clear
    tag = "R4"; set_code(31, T_HIGH); tick();
    pin_lvl[31] = 1'b1; tick(); expect_bit(31, 1'b1, "R4");
    clear(31); expect_bit(31, 1'b1, "R4");
    pin_lvl[31] = 1'b0; clear(31); expect_bit(31, 1'b0, "R5");
    set_code(30, T_LOW); tick(); expect_bit(30, 1'b1, "R4");
    set_code(30, T_FALL); clear(30); expect_bit(30, 1'b0, "R5");

    // R5 zero bits of clear do nothing
    tag = "R5"; pin_lvl[1] = 1'b1; tick(); pin_lvl[1] = 1'b0; tick();
    expect_bit(1, 1'b1, "R5");
    sts_clr = '1; sts_clr[1] = 1'b0; tick(); sts_clr = '0;
    expect_bit(1, 1'b1, "R5");
    clear(1);

    // R6 edge and clear in the same cycle
    tag = "R6"; pin_lvl[2] = 1'b1; tick(); pin_lvl[2] = 1'b0; tick();
    pin_lvl[2] = 1'b1; tick();
    pin_lvl[2] = 1'b0; sts_clr[2] = 1'b1; tick(); sts_clr = '0;
    expect_bit(2, 1'b1, "R6");
    clear(2);

    // R7 disabled status does not raise irq
    tag = "R7"; irq_en = '0; pin_lvl[3] = 1'b1; tick(); pin_lvl[3] = 1'b0; tick(3);
    irq_en[3] = 1'b1; tick(2);
    clear(3); tick(2);

    // R8 type change together with a level move
    tag = "R8"; set_code(5, T_RISE); tick(2);
    pin_lvl[5] = 1'b1; tick(); clear(5); tick();
    set_code(5, T_FALL); pin_lvl[5] = 1'b0; tick(); expect_bit(5, 1'b0, "R8");
    tick(2); expect_bit(5, 1'b0, "R8");

    // random phase
    tag = "R8";
    for (int c = 0; c < 3000; c++) begin
      for (int g = 0; g < NB; g++) begin
        if ($urandom_range(0, 15) == 0) begin
          case ($urandom_range(0, 4))
            0: set_code(g, T_RISE);
            1: set_code(g, T_FALL);
            2: set_code(g, T_BOTH);
            3: set_code(g, T_HIGH);
            default: set_code(g, T_LOW);
          endcase
        end
        if ($urandom_range(0, 3) == 0) pin_lvl[g] = ~pin_lvl[g];
        sts_clr[g] = ($urandom_range(0, 5) == 0);
        if ($urandom_range(0, 31) == 0) irq_en[g] = ~irq_en[g];
      end
      tick();
    end
    sts_clr = '0;
    tag = "R9"; rst = 1'b1; tick(2); rst = 1'b0; tick(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule